// File: doc/BRIEF.md
# Supervisory Watchdog Timer with Reset Pulse

This block supervises a processor through a single kick line. Every transition of that line, rising or falling, restarts a tick counter. If the counter reaches its limit before the next transition, the block drives an active-low reset pulse for a fixed number of ticks. It also lowers a separate active-low fault flag, which stays low until software kicks again. After a pulse ends, the block waits out a longer grace period before the normal timeout applies again. A kick line that never moves therefore produces a steady train of reset pulses.

The time base is selectable. With the select input low, one tick is counted for every cycle in which an external clock-enable is high. With the select input high, an internal prescaler divides the system clock. Two digital inputs stop the timer. The disable input plays the role of a floated kick pin. The supply-low input models a brown-out, and it also forces the fault flag high. The block comes out of its own synchronous reset inside a reset pulse, so a power-on reset is issued.

Top module: `wdog_supervisor`

## Requirements
- R1: A rising or a falling edge on `kick_i` restarts the timeout count from zero and selects the normal timeout. The edge takes effect two clock edges after the first edge that samples the new level, because it passes through a two-stage synchronizer. Kicks spaced closer than the timeout keep `rst_n_o` high indefinitely.
- R2: While `kick_i` stays constant, reset pulses repeat. Each pulse is followed by a high interval of `POST_TICKS` ticks, and then the next pulse starts.
- R3: After a kick edge takes effect, `rst_n_o` goes low once `NORMAL_TICKS` further ticks have passed with no other kick edge.
- R4: Each reset pulse holds `rst_n_o` low for exactly `PULSE_TICKS` ticks. The pulse cannot end on a cycle without a tick.
- R5: When a pulse ends, the timeout in force is `POST_TICKS`, which is longer than `NORMAL_TICKS`. It stays in force until a kick edge arrives.
- R6: `wdf_n_o` falls in the same cycle that a timeout starts a reset pulse. It then stays low until a kick edge outside a pulse, or supply-low, sets it high.
- R7: While `supply_low_i` is 1, the timer is halted and `rst_n_o` and `wdf_n_o` are both high from the next cycle onward.
- R8: While `wd_off_i` is 1, no timeout and no pulse occur, and `rst_n_o` is high from the next cycle onward. Once `wd_off_i` returns to 0, counting restarts from zero with the normal timeout.
- R9: When `clk_src_sel_i` is 0, a tick is any cycle with `ext_tick_i` = 1, and the count freezes while `ext_tick_i` = 0. When `clk_src_sel_i` is 1, a tick occurs once every `PRESCALE` clock cycles.
- R10: A kick edge that takes effect during a reset pulse is ignored. It neither shortens the pulse, nor raises `wdf_n_o`, nor changes the next timeout.
- R11: While and after `rst` is 1, `rst_n_o` is low (a power-on pulse of `PULSE_TICKS` ticks follows) and `wdf_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Watchdog kick line, asynchronous; either edge restarts the count |
| wd_off_i | input | 1 | 1 halts the watchdog (stands in for a floated kick pin) |
| supply_low_i | input | 1 | 1 while supply is low: timer halted, fault flag forced high |
| clk_src_sel_i | input | 1 | 0 = count external enable, 1 = internal prescaled tick |
| ext_tick_i | input | 1 | External time-base enable, one tick per cycle high |
| rst_n_o | output | 1 | Active-low reset pulse |
| wdf_n_o | output | 1 | Active-low latched watchdog fault flag |

## Verification
The properties assume that `wd_off_i`, `supply_low_i`, `clk_src_sel_i` and `ext_tick_i` are already synchronous to `clk`, since the block samples them without synchronizers. Only `kick_i` may change freely. The stimulus changes every input only at the falling clock edge. It holds each kick level for many cycles, so every transition yields exactly one synchronized edge. The select input is changed only while the model and design are both compared cycle by cycle, so a prescaler phase that is unknown at the switch costs nothing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Defaults assume a 1 ms tick from the prescaler.
    localparam int unsigned WD_PRESCALE_DEF = 1000;
    localparam int unsigned WD_NORMAL_DEF   = 1600;  // about 1.6 s
    localparam int unsigned WD_SHORT_DEF    = 100;   // about 100 ms alternative
    localparam int unsigned WD_POST_DEF     = 3200;  // grace period after a pulse
    localparam int unsigned WD_PULSE_DEF    = 200;

    typedef enum logic [1:0] {
        PH_GRACE = 2'd0,  // counting with the post-pulse limit
        PH_ARMED = 2'd1,  // counting with the normal limit
        PH_PULSE = 2'd2,  // reset pulse active
        PH_HALT  = 2'd3   // disabled or supply low
    } wd_phase_e;

    typedef struct packed {
        logic rst_n;
        logic wdf_n;
    } wd_out_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned phase_limit(input wd_phase_e ph,
                                                input int unsigned normal_t,
                                                input int unsigned grace_t,
                                                input int unsigned pulse_t);
        case (ph)
            PH_GRACE: return grace_t;
            PH_PULSE: return pulse_t;
            default:  return normal_t;
        endcase
    endfunction

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_async,
    output logic kick_edge
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= kick_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], kick_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign kick_edge = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int unsigned PRESCALE = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic src_sel,
    input  logic ext_tick,
    output logic tick
);
    logic int_tick;

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign int_tick = 1'b1;
        end else begin : g_div
            localparam int unsigned PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst)                pre_q <= '0;
                else if (pre_q == LAST) pre_q <= '0;
                else                    pre_q <= pre_q + PW'(1);
            end
            assign int_tick = (pre_q == LAST);
        end
    endgenerate

    assign tick = src_sel ? int_tick : ext_tick;
endmodule

// File: rtl/wdog_timer_fsm.sv
module wdog_timer_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned NORMAL_TICKS = WD_NORMAL_DEF,
    parameter int unsigned POST_TICKS   = WD_POST_DEF,
    parameter int unsigned PULSE_TICKS  = WD_PULSE_DEF
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    kick_edge,
    input  logic    halt_req,
    input  logic    supply_low,
    output wd_out_t outs
);
    localparam int unsigned MAX_T = max3(NORMAL_TICKS, POST_TICKS, PULSE_TICKS);
    localparam int unsigned CNT_W = $clog2(MAX_T + 1);

    wd_phase_e        ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;
    logic             wdf_q, wdf_d;
    logic             expire;

    always_comb begin
        lim_m1 = CNT_W'(phase_limit(ph_q, NORMAL_TICKS, POST_TICKS, PULSE_TICKS) - 1);
        expire = tick && (cnt_q == lim_m1);
    end

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        wdf_d = wdf_q;
        if (supply_low || halt_req) begin
            ph_d  = PH_HALT;
            cnt_d = '0;
            if (supply_low || kick_edge) wdf_d = 1'b1;
        end else begin
            case (ph_q)
                PH_HALT: begin
                    ph_d  = PH_ARMED;
                    cnt_d = '0;
                    if (kick_edge) wdf_d = 1'b1;
                end
                PH_PULSE: begin
                    if (expire) begin
                        ph_d  = PH_GRACE;
                        cnt_d = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    if (kick_edge) begin
                        ph_d  = PH_ARMED;
                        cnt_d = '0;
                        wdf_d = 1'b1;
                    end else if (expire) begin
                        ph_d  = PH_PULSE;
                        cnt_d = '0;
                        wdf_d = 1'b0;
                    end else if (tick) begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_PULSE;
            cnt_q <= '0;
            wdf_q <= 1'b1;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            wdf_q <= wdf_d;
        end
    end

    assign outs.rst_n = (ph_q != PH_PULSE);
    assign outs.wdf_n = wdf_q;
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int unsigned PRESCALE     = WD_PRESCALE_DEF,
    parameter int unsigned NORMAL_TICKS = WD_NORMAL_DEF,
    parameter int unsigned POST_TICKS   = WD_POST_DEF,
    parameter int unsigned PULSE_TICKS  = WD_PULSE_DEF,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    input  logic wd_off_i,
    input  logic supply_low_i,
    input  logic clk_src_sel_i,
    input  logic ext_tick_i,
    output logic rst_n_o,
    output logic wdf_n_o
);
    logic    kick_edge;
    logic    tick;
    wd_out_t outs;

    wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .kick_async (kick_i),
        .kick_edge  (kick_edge)
    );

    wdog_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (clk_src_sel_i),
        .ext_tick (ext_tick_i),
        .tick     (tick)
    );

    wdog_timer_fsm #(
        .NORMAL_TICKS (NORMAL_TICKS),
        .POST_TICKS   (POST_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .kick_edge  (kick_edge),
        .halt_req   (wd_off_i),
        .supply_low (supply_low_i),
        .outs       (outs)
    );

    assign rst_n_o = outs.rst_n;
    assign wdf_n_o = outs.wdf_n;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic off,
    input logic vlow,
    input logic src_sel,
    input logic ext_tick,
    input logic kick_edge,
    input logic rst_n,
    input logic wdf_n
);
    assert_vlow_forces_high_R7: assert property (@(posedge clk) disable iff (rst)
        vlow |=> (wdf_n && rst_n));

    assert_off_no_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        off |=> rst_n);

    assert_fault_with_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(wdf_n) |-> (!rst_n && $past(rst_n)));

    assert_fault_release_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(wdf_n) |-> ($past(kick_edge) || $past(vlow) || $past(rst)));

    assert_kick_keeps_alive_R1: assert property (@(posedge clk) disable iff (rst)
        (kick_edge && rst_n && !off && !vlow) |=> rst_n);

    assert_no_tick_no_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        (!src_sel && !ext_tick && rst_n && !off && !vlow) |=> rst_n);

    assert_pulse_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (!src_sel && !ext_tick && !rst_n && !off && !vlow) |=> !rst_n);

    assert_kick_in_pulse_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (kick_edge && !rst_n && !off && !vlow) |=> $stable(wdf_n));
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .off       (wd_off_i),
    .vlow      (supply_low_i),
    .src_sel   (clk_src_sel_i),
    .ext_tick  (ext_tick_i),
    .kick_edge (kick_edge),
    .rst_n     (rst_n_o),
    .wdf_n     (wdf_n_o)
);

// File: tb/wdog_supervisor_tb.sv
`timescale 1ns/1ps
module wdog_supervisor_tb;
    localparam int DIV    = 3;
    localparam int NORMAL = 6;
    localparam int POST   = 10;
    localparam int PULSE  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick = 1'b0, off = 1'b0, vlow = 1'b0, src = 1'b0, ext = 1'b1;
    logic rst_n_o, wdf_n_o;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R11";
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    wdog_supervisor #(
        .PRESCALE(DIV), .NORMAL_TICKS(NORMAL), .POST_TICKS(POST),
        .PULSE_TICKS(PULSE), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst(rst), .kick_i(kick), .wd_off_i(off),
        .supply_low_i(vlow), .clk_src_sel_i(src), .ext_tick_i(ext),
        .rst_n_o(rst_n_o), .wdf_n_o(wdf_n_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 grace, 1 normal, 2 pulse, 3 halted.
    int m_pre = 0, m_ph = 2, m_cnt = 0, m_lim = 0;
    bit m_s1 = 0, m_s2 = 0, m_prev = 0, m_wdf = 1, m_e = 0, m_t = 0;

    always @(posedge clk) begin
        m_e = (m_s2 != m_prev);
        m_t = src ? (m_pre == DIV - 1) : ext;
        if (rst) begin
            m_pre = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_ph = 2; m_cnt = 0; m_wdf = 1;
        end else begin
            m_pre  = (m_pre == DIV - 1) ? 0 : m_pre + 1;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = kick;
            m_lim  = (m_ph == 0) ? POST : (m_ph == 2) ? PULSE : NORMAL;
            if (vlow || off) begin
                if (vlow || m_e) m_wdf = 1;
                m_ph = 3; m_cnt = 0;
            end else if (m_ph == 3) begin
                if (m_e) m_wdf = 1;
                m_ph = 1; m_cnt = 0;
            end else if (m_ph == 2) begin
                if (m_t) begin
                    if (m_cnt + 1 == m_lim) begin m_ph = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            end else if (m_e) begin
                m_ph = 1; m_cnt = 0; m_wdf = 1;
            end else if (m_t) begin
                if (m_cnt + 1 == m_lim) begin m_ph = 2; m_cnt = 0; m_wdf = 0; end
                else m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(rst_n_o === (m_ph != 2), cur_req, "model rst_n", int'(rst_n_o), int'(m_ph != 2));
            chk(wdf_n_o === m_wdf, cur_req, "model wdf_n", int'(wdf_n_o), int'(m_wdf));
        end
    end

    task automatic wait_level(input logic lvl);
        while (rst_n_o !== lvl) @(negedge clk);
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (rst_n_o === lvl) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired, run hung");
        finish_run();
    end

    initial begin
        int n;
        bit ok;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rst_n_o === 1'b0, "R11", "rst_n in reset", int'(rst_n_o), 0);
        chk(wdf_n_o === 1'b1, "R11", "wdf_n in reset", int'(wdf_n_o), 1);
        cmp_en = 1'b1;
        rst = 1'b0;

        // R5, R4, R2: static kick, external tick every cycle
        cur_req = "R2";
        wait_level(1'b1);
        run_len(1'b1, n); chk(n == POST, "R5", "grace high length", n, POST);
        chk(wdf_n_o === 1'b0, "R6", "wdf low at timeout", int'(wdf_n_o), 0);
        run_len(1'b0, n); chk(n == PULSE, "R4", "pulse length", n, PULSE);
        run_len(1'b1, n); chk(n == POST, "R2", "repeat interval", n, POST);

        // R10: kick during pulse ignored
        cur_req = "R10";
        kick = 1'b1;
        run_len(1'b0, n); chk(n == PULSE, "R10", "pulse not shortened", n, PULSE);
        chk(wdf_n_o === 1'b0, "R10", "wdf stays low", int'(wdf_n_o), 0);

        // R6 release, R3 normal timeout after a falling kick edge
        cur_req = "R3";
        kick = 1'b0;
        repeat (4) @(negedge clk);
        chk(wdf_n_o === 1'b1, "R6", "wdf released by kick", int'(wdf_n_o), 1);
        run_len(1'b1, n); chk(n == NORMAL - 1, "R3", "normal timeout tail", n, NORMAL - 1);
        chk(wdf_n_o === 1'b0, "R6", "wdf low again", int'(wdf_n_o), 0);

        // R1: periodic kicks keep reset high
        cur_req = "R1";
        wait_level(1'b1);
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            kick = ~kick;
            repeat (NORMAL - 1) begin
                @(negedge clk);
                if (rst_n_o !== 1'b1) ok = 1'b0;
            end
        end
        chk(ok, "R1", "reset held off by kicks", int'(ok), 1);

        // R7: supply low
        cur_req = "R7";
        wait_level(1'b0);
        vlow = 1'b1;
        @(negedge clk);
        chk(wdf_n_o === 1'b1, "R7", "wdf forced high", int'(wdf_n_o), 1);
        chk(rst_n_o === 1'b1, "R7", "rst_n high", int'(rst_n_o), 1);
        ok = 1'b1;
        repeat (3 * POST) begin @(negedge clk); if (rst_n_o !== 1'b1) ok = 1'b0; end
        chk(ok, "R7", "no pulse while supply low", int'(ok), 1);

        // R8: disable, then restart with normal limit
        cur_req = "R8";
        vlow = 1'b0; off = 1'b1;
        ok = 1'b1;
        repeat (30) begin @(negedge clk); if (rst_n_o !== 1'b1) ok = 1'b0; end
        chk(ok, "R8", "no pulse while disabled", int'(ok), 1);
        off = 1'b0;
        run_len(1'b1, n); chk(n == NORMAL + 1, "R8", "restart high length", n, NORMAL + 1);

        // R9: external enable frozen, then internal prescaler
        cur_req = "R9";
        wait_level(1'b1);
        ext = 1'b0;
        ok = 1'b1;
        repeat (40) begin @(negedge clk); if (rst_n_o !== 1'b1) ok = 1'b0; end
        chk(ok, "R9", "count frozen without ext tick", int'(ok), 1);
        ext = 1'b1;
        run_len(1'b1, n); chk(n == POST, "R9", "resumed grace length", n, POST);
        src = 1'b1;
        wait_level(1'b1);
        wait_level(1'b0);
        wait_level(1'b1);
        run_len(1'b1, n); chk(n == POST * DIV, "R9", "internal grace length", n, POST * DIV);
        run_len(1'b0, n); chk(n == PULSE * DIV, "R9", "internal pulse length", n, PULSE * DIV);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule